// File: doc/BRIEF.md
# Auxiliary Control Packet Store

This block keeps short side-band packets (time stamps and similar control words) that travel next to a video frame stream. Packets arrive as a beat stream marked with start and end flags and carry the number of the frame they came with. Each packet is 1, 2 or 4 beats long. All packets share one pool of storage that is counted in beats. When a new packet does not fit, whole packets are thrown out, oldest first, until it does.

Stored packets leave the block only when the frame logic issues a release command. With frame binding enabled, a play command for frame F emits the packets at the front of the store that carry tag F and keeps them. The command can therefore be repeated, which gives the replay for a repeated frame. A free command for frame F removes those packets without emitting them, which covers both a retired frame and a dropped frame. With frame binding disabled, a play command drains every stored packet in arrival order whatever its tag, and free commands do nothing. The capacity setting is in units of four beats, and a setting of zero builds no storage at all.

Top module: `aux_pkt_store`

## Requirements
- R1: After reset the store is empty, `out_valid` and `rel_busy` are low, and a play command emits no beats.
- R2: Packets of 1, 2 and 4 beats can be mixed in any order. A release emits them in arrival order with `out_sop` on the first beat and `out_eop` on the last, and `out_frame` carries the tag the packet arrived with.
- R3: A packet whose length is not 1, 2 or 4 beats (for example 3 or 5) is discarded whole. A beat that arrives with `in_sop` low and no packet open is ignored.
- R4: Total storage is 4*CAP beats. Packets that fill it exactly are all kept.
- R5: An arriving packet that needs more beats than are free removes the oldest whole packets, one by one, until it fits. No packet is ever partly overwritten.
- R6: With ASSOC=1, a play command for frame F emits the packets at the front of the store whose tag equals F, stops at the first packet with another tag, and removes nothing. Repeating the command gives the same beats again.
- R7: With ASSOC=1, a free command for frame F silently removes the front packets tagged F. If the front packet has another tag, nothing is removed.
- R8: With ASSOC=0, a play command emits every stored packet, whatever its tag, and empties the store. A free command has no effect.
- R9: `rel_busy` is high from the cycle after an accepted command until the release ends. Commands are taken only while `rel_busy` is low. If play and free are both high, play is taken and free is dropped.
- R10: While a play is running, packets it has not yet passed cannot be removed by an arrival. An arriving packet that cannot fit without removing them is discarded.
- R11: With CAP=0 nothing is stored, `out_valid` never rises and `rel_busy` stays low.
- R12: The beats of one release leave on consecutive clock cycles with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | DW | Input beat payload |
| in_frame | input | FW | Frame tag, taken on the first beat |
| rel_play | input | 1 | Play command |
| rel_free | input | 1 | Free command |
| rel_frame | input | FW | Frame tag the command refers to |
| rel_busy | output | 1 | A command is being carried out |
| out_valid | output | 1 | Output beat present |
| out_sop | output | 1 | First beat of an emitted packet |
| out_eop | output | 1 | Last beat of an emitted packet |
| out_data | output | DW | Output beat payload |
| out_frame | output | FW | Tag of the emitted packet |

## Verification
A head or tail pointer that is out of step shows up at the next play command. The beats come out shifted, truncated or run past the packet end, and the start and end flags no longer line up with the 1, 2 or 4 beat lengths, so a single release exposes it. A wrong free-space count shows up as a wrong choice of which packet gets evicted, visible the next time the store is released after it fills. A wrong passed-packet count during a play either lets an arrival evict a packet that has not yet been emitted, which is visible within the same release, or emits a packet twice.

// File: rtl/aux_pkt_pkg.sv
package aux_pkt_pkg;

    localparam int unsigned MAX_BEATS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAY = 2'd1,
        ST_FREE = 2'd2
    } rel_st_e;

    // Legal packet lengths are 1, 2 and 4 beats.
    function automatic logic len_legal(input logic [3:0] len);
        return (len == 4'd1) || (len == 4'd2) || (len == 4'd4);
    endfunction

endpackage

// File: rtl/aux_pkt_assembler.sv
module aux_pkt_assembler #(
    parameter int unsigned DW = 32,
    parameter int unsigned FW = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic                             in_sop,
    input  logic                             in_eop,
    input  logic [DW-1:0]                    in_data,
    input  logic [FW-1:0]                    in_frame,
    output logic                             commit,
    output logic [2:0]                       commit_len,
    output logic [FW-1:0]                    commit_tag,
    output logic [aux_pkt_pkg::MAX_BEATS-1:0][DW-1:0] commit_beats
);
    import aux_pkt_pkg::*;

    localparam int unsigned NSTG = MAX_BEATS - 1;

    typedef struct packed {
        logic                      active;
        logic                      ovf;
        logic [2:0]                cnt;
        logic [FW-1:0]             tag;
        logic [NSTG-1:0][DW-1:0]   stg;
    } asm_t;

    asm_t q, d;
    logic [3:0] len_w;

    always_comb begin
        d      = q;
        len_w  = 4'd0;
        commit = 1'b0;
        if (in_valid) begin
            if (in_sop) begin
                d.active = 1'b1;
                d.ovf    = 1'b0;
                d.cnt    = 3'd1;
                d.tag    = in_frame;
                d.stg[0] = in_data;
                len_w    = 4'd1;
            end else if (q.active) begin
                if (q.cnt >= 3'(MAX_BEATS)) begin
                    d.ovf = 1'b1;
                end else begin
                    if (q.cnt < 3'(NSTG)) begin
                        d.stg[q.cnt[1:0]] = in_data;
                    end
                    d.cnt = q.cnt + 3'd1;
                end
                len_w = q.ovf ? 4'd15 : ({1'b0, q.cnt} + 4'd1);
            end
            if (in_eop && (in_sop || q.active)) begin
                d.active = 1'b0;
                commit   = len_legal(len_w);
            end
        end
    end

    always_comb begin
        commit_len = len_w[2:0];
        commit_tag = in_sop ? in_frame : q.tag;
        for (int j = 0; j < MAX_BEATS; j++) begin
            if ((4'(j) + 4'd1 == len_w) || (j >= NSTG)) begin
                commit_beats[j] = in_data;
            end else begin
                commit_beats[j] = q.stg[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/aux_pkt_beat_ram.sv
module aux_pkt_beat_ram #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned NW    = 4,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic [NW-1:0]           wr_en,
    input  logic [NW-1:0][AW-1:0]   wr_addr,
    input  logic [NW-1:0][DW-1:0]   wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NW; p++) begin
            if (wr_en[p]) begin
                mem[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/aux_pkt_desc_ram.sv
module aux_pkt_desc_ram #(
    parameter int unsigned FW    = 4,
    parameter int unsigned DEPTH = 32,
    parameter int unsigned NR    = 6,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [2:0]              wr_len,
    input  logic [FW-1:0]           wr_tag,
    input  logic [NR-1:0][AW-1:0]   rd_addr,
    output logic [NR-1:0][2:0]      rd_len,
    output logic [NR-1:0][FW-1:0]   rd_tag
);
    logic [2:0]    len_mem [DEPTH];
    logic [FW-1:0] tag_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            len_mem[wr_addr] <= wr_len;
            tag_mem[wr_addr] <= wr_tag;
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        assign rd_len[r] = len_mem[rd_addr[r]];
        assign rd_tag[r] = tag_mem[rd_addr[r]];
    end

endmodule

// File: rtl/aux_pkt_store.sv
module aux_pkt_store #(
    parameter int unsigned DW    = 32,
    parameter int unsigned FW    = 4,
    parameter int unsigned CAP   = 8,
    parameter bit          ASSOC = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [DW-1:0] in_data,
    input  logic [FW-1:0] in_frame,
    input  logic          rel_play,
    input  logic          rel_free,
    input  logic [FW-1:0] rel_frame,
    output logic          rel_busy,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [DW-1:0] out_data,
    output logic [FW-1:0] out_frame
);
    import aux_pkt_pkg::*;

    localparam int unsigned NB  = CAP * MAX_BEATS;
    localparam int unsigned NBS = (NB < MAX_BEATS) ? MAX_BEATS : NB;
    localparam int unsigned AW  = $clog2(NBS);
    localparam int unsigned CW  = AW + 1;
    localparam int unsigned NRD = MAX_BEATS + 2;
    localparam int unsigned RDP = NRD - 1;

    if (CAP == 0) begin : g_none
        logic unused_inputs;
        assign unused_inputs = ^{clk, rst_n, in_valid, in_sop, in_eop, in_data,
                                 in_frame, rel_play, rel_free, rel_frame};
        assign rel_busy  = 1'b0;
        assign out_valid = 1'b0;
        assign out_sop   = 1'b0;
        assign out_eop   = 1'b0;
        assign out_data  = '0;
        assign out_frame = '0;
    end else begin : g_store

        typedef struct packed {
            rel_st_e        st;
            logic [AW-1:0]  dhead;
            logic [AW-1:0]  dtail;
            logic [AW-1:0]  bhead;
            logic [AW-1:0]  btail;
            logic [AW-1:0]  rd_b;
            logic [CW-1:0]  dcnt;
            logic [CW-1:0]  used;
            logic [CW-1:0]  rd_n;
            logic [1:0]     rd_k;
            logic [FW-1:0]  frame;
            logic           ov;
            logic           osop;
            logic           oeop;
            logic [DW-1:0]  odata;
            logic [FW-1:0]  oframe;
        } ctl_t;

        ctl_t q, d;

        logic                                  a_commit;
        logic [2:0]                            a_len;
        logic [FW-1:0]                         a_tag;
        logic [MAX_BEATS-1:0][DW-1:0]          a_beats;

        logic [MAX_BEATS-1:0]                  bw_en;
        logic [MAX_BEATS-1:0][AW-1:0]          bw_addr;
        logic [DW-1:0]                         br_data;

        logic                                  dw_en;
        logic [NRD-1:0][AW-1:0]                dr_addr;
        logic [NRD-1:0][2:0]                   dr_len;
        logic [NRD-1:0][FW-1:0]                dr_tag;

        aux_pkt_assembler #(.DW(DW), .FW(FW)) u_asm (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_valid     (in_valid),
            .in_sop       (in_sop),
            .in_eop       (in_eop),
            .in_data      (in_data),
            .in_frame     (in_frame),
            .commit       (a_commit),
            .commit_len   (a_len),
            .commit_tag   (a_tag),
            .commit_beats (a_beats)
        );

        aux_pkt_beat_ram #(.DW(DW), .DEPTH(NBS), .NW(MAX_BEATS)) u_beats (
            .clk     (clk),
            .wr_en   (bw_en),
            .wr_addr (bw_addr),
            .wr_data (a_beats),
            .rd_addr (q.rd_b),
            .rd_data (br_data)
        );

        aux_pkt_desc_ram #(.FW(FW), .DEPTH(NBS), .NR(NRD)) u_desc (
            .clk     (clk),
            .wr_en   (dw_en),
            .wr_addr (q.dtail),
            .wr_len  (a_len),
            .wr_tag  (a_tag),
            .rd_addr (dr_addr),
            .rd_len  (dr_len),
            .rd_tag  (dr_tag)
        );

        // Ports 0..4 look at the oldest packets in order; the last port
        // follows the packet the release walker is on.
        always_comb begin
            for (int i = 0; i < NRD - 1; i++) begin
                dr_addr[i] = q.dhead + AW'(i);
            end
            dr_addr[RDP] = q.dhead + q.rd_n[AW-1:0];
        end

        always_comb begin
            logic           pop_walk;
            logic           emit;
            logic [AW-1:0]  h;
            logic [AW-1:0]  hb;
            logic [CW-1:0]  c;
            logic [CW-1:0]  u;
            logic [CW-1:0]  rn;
            logic [CW-1:0]  room;
            int             k;

            d        = q;
            pop_walk = 1'b0;
            emit     = 1'b0;
            bw_en    = '0;
            dw_en    = 1'b0;
            d.ov     = 1'b0;
            d.osop   = 1'b0;
            d.oeop   = 1'b0;

            for (int j = 0; j < MAX_BEATS; j++) begin
                bw_addr[j] = q.btail + AW'(j);
            end

            // release walker
            unique case (q.st)
                ST_IDLE: begin
                    if (rel_play) begin
                        d.st    = ST_PLAY;
                        d.frame = rel_frame;
                        d.rd_n  = '0;
                        d.rd_b  = q.bhead;
                        d.rd_k  = '0;
                    end else if (rel_free && ASSOC) begin
                        d.st    = ST_FREE;
                        d.frame = rel_frame;
                    end
                end
                ST_PLAY: begin
                    emit = (q.dcnt != q.rd_n) &&
                           (!ASSOC || (dr_tag[RDP] == q.frame));
                    if (emit) begin
                        d.ov     = 1'b1;
                        d.osop   = (q.rd_k == 2'd0);
                        d.oeop   = ({1'b0, q.rd_k} + 3'd1 == dr_len[RDP]);
                        d.odata  = br_data;
                        d.oframe = dr_tag[RDP];
                        d.rd_b   = q.rd_b + AW'(1);
                        if (d.oeop) begin
                            d.rd_k = '0;
                            if (ASSOC) begin
                                d.rd_n = q.rd_n + CW'(1);
                            end else begin
                                pop_walk = 1'b1;
                            end
                        end else begin
                            d.rd_k = q.rd_k + 2'd1;
                        end
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_FREE: begin
                    if ((q.dcnt != '0) && (dr_tag[0] == q.frame)) begin
                        pop_walk = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase

            // head pops: walker first, then eviction for an arrival
            h  = q.dhead;
            hb = q.bhead;
            c  = q.dcnt;
            u  = q.used;
            rn = d.rd_n;
            k  = 0;
            if (pop_walk) begin
                u  = u - CW'(dr_len[0]);
                hb = hb + AW'(dr_len[0]);
                h  = h + AW'(1);
                c  = c - CW'(1);
                k  = 1;
            end

            if (a_commit) begin
                for (int e = 0; e < MAX_BEATS; e++) begin
                    room = CW'(NB) - u;
                    if ((room < CW'(a_len)) &&
                        (((d.st == ST_PLAY) ? rn : c) != '0)) begin
                        u  = u - CW'(dr_len[k]);
                        hb = hb + AW'(dr_len[k]);
                        h  = h + AW'(1);
                        c  = c - CW'(1);
                        if (d.st == ST_PLAY) begin
                            rn = rn - CW'(1);
                        end
                        k  = k + 1;
                    end
                end
                room = CW'(NB) - u;
                if (room >= CW'(a_len)) begin
                    dw_en = 1'b1;
                    for (int j = 0; j < MAX_BEATS; j++) begin
                        bw_en[j] = (3'(j) < a_len);
                    end
                    d.dtail = q.dtail + AW'(1);
                    d.btail = q.btail + AW'(a_len);
                    c       = c + CW'(1);
                    u       = u + CW'(a_len);
                end
            end

            d.dhead = h;
            d.bhead = hb;
            d.dcnt  = c;
            d.used  = u;
            d.rd_n  = rn;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end

        assign rel_busy  = (q.st != ST_IDLE);
        assign out_valid = q.ov;
        assign out_sop   = q.osop;
        assign out_eop   = q.oeop;
        assign out_data  = q.odata;
        assign out_frame = q.oframe;
    end

endmodule

// File: rtl/aux_pkt_store_chk.sv
module aux_pkt_store_chk #(
    parameter int unsigned FW  = 4,
    parameter int unsigned CAP = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rel_play,
    input logic          rel_free,
    input logic          rel_busy,
    input logic          out_valid,
    input logic          out_sop,
    input logic          out_eop,
    input logic [FW-1:0] out_frame
);
    // R9
    valid_in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rel_busy);

    // R12
    no_gap_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> (out_valid && !out_sop));

    // R2
    packet_starts_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |=> (!out_valid || out_sop));

    // R2
    tag_steady_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> $stable(out_frame));

    // R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel_busy && !rel_play && !rel_free) |=> !rel_busy);

    if (CAP == 0) begin : g_zero
        // R11
        cap_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid && !rel_busy);
    end else begin : g_some
        // R9
        play_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rel_busy && rel_play) |=> rel_busy);
    end

endmodule

bind aux_pkt_store aux_pkt_store_chk #(.FW(FW), .CAP(CAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_play  (rel_play),
    .rel_free  (rel_free),
    .rel_busy  (rel_busy),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_frame (out_frame)
);

// File: tb/tb_aux_pkt_store.sv
`timescale 1ns/1ps
module tb_aux_pkt_store;

    localparam int DW = 16;
    localparam int FW = 4;

    typedef struct {
        logic [DW-1:0] d;
        logic          s;
        logic          e;
        logic [FW-1:0] f;
        int            t;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [FW-1:0] in_frame = '0;
    logic rel_play = 1'b0, rel_free = 1'b0;
    logic [FW-1:0] rel_frame = '0;
    logic rel_play_n = 1'b0, rel_free_n = 1'b0;

    logic busy_a, ov_a, os_a, oe_a;
    logic [DW-1:0] od_a;
    logic [FW-1:0] of_a;
    logic busy_n, ov_n, os_n, oe_n;
    logic [DW-1:0] od_n;
    logic [FW-1:0] of_n;
    logic busy_z, ov_z, os_z, oe_z;
    logic [DW-1:0] od_z;
    logic [FW-1:0] of_z;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int zhits = 0;
    beat_t qa[$];
    beat_t qn[$];
    beat_t ex[$];

    always #2 clk = ~clk;

    aux_pkt_store #(.DW(DW), .FW(FW), .CAP(2), .ASSOC(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_frame(in_frame),
        .rel_play(rel_play), .rel_free(rel_free), .rel_frame(rel_frame),
        .rel_busy(busy_a), .out_valid(ov_a), .out_sop(os_a), .out_eop(oe_a),
        .out_data(od_a), .out_frame(of_a));

    aux_pkt_store #(.DW(DW), .FW(FW), .CAP(2), .ASSOC(1'b0)) dut_na (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_frame(in_frame),
        .rel_play(rel_play_n), .rel_free(rel_free_n), .rel_frame(rel_frame),
        .rel_busy(busy_n), .out_valid(ov_n), .out_sop(os_n), .out_eop(oe_n),
        .out_data(od_n), .out_frame(of_n));

    aux_pkt_store #(.DW(DW), .FW(FW), .CAP(0), .ASSOC(1'b1)) dut_z (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_frame(in_frame),
        .rel_play(rel_play), .rel_free(rel_free), .rel_frame(rel_frame),
        .rel_busy(busy_z), .out_valid(ov_z), .out_sop(os_z), .out_eop(oe_z),
        .out_data(od_z), .out_frame(of_z));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ov_a) qa.push_back('{d: od_a, s: os_a, e: oe_a, f: of_a, t: cyc});
            if (ov_n) qn.push_back('{d: od_n, s: os_n, e: oe_n, f: of_n, t: cyc});
            if (ov_z || busy_z || os_z || oe_z) zhits++;
        end
    end

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        rel_play = 1'b0; rel_free = 1'b0; rel_play_n = 1'b0; rel_free_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        qa.delete(); qn.delete(); ex.delete();
    endtask

    // beat j of packet id carries id*16+j
    task automatic send_pkt(input int id, input int len, input int fr);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (j == 0);
            in_eop   = (j == len - 1);
            in_data  = DW'(id * 16 + j);
            in_frame = FW'(fr);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic exp_pkt(input int id, input int len, input int fr);
        for (int j = 0; j < len; j++) begin
            ex.push_back('{d: DW'(id * 16 + j), s: (j == 0), e: (j == len - 1),
                           f: FW'(fr), t: 0});
        end
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy_a || busy_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input bit play, input bit free, input int fr, input bit na);
        @(negedge clk);
        rel_frame = FW'(fr);
        if (na) begin rel_play_n = play; rel_free_n = free; end
        else    begin rel_play   = play; rel_free   = free; end
        @(negedge clk);
        rel_play = 1'b0; rel_free = 1'b0; rel_play_n = 1'b0; rel_free_n = 1'b0;
        wait_idle();
    endtask

    // compare collected beats of one instance against ex, then clear both
    task automatic check_out(input bit na, input string req);
        beat_t got[$];
        bit ok;
        string msg;
        got = na ? qn : qa;
        ok  = (got.size() == ex.size());
        msg = $sformatf("beats actual %0d expected %0d", got.size(), ex.size());
        for (int i = 0; ok && i < got.size(); i++) begin
            if (got[i].d !== ex[i].d || got[i].s !== ex[i].s ||
                got[i].e !== ex[i].e || got[i].f !== ex[i].f) begin
                ok  = 1'b0;
                msg = $sformatf("beat %0d actual d=%h s=%b e=%b f=%0d expected d=%h s=%b e=%b f=%0d",
                                i, got[i].d, got[i].s, got[i].e, got[i].f,
                                ex[i].d, ex[i].s, ex[i].e, ex[i].f);
            end
        end
        check(ok, req, msg);
        for (int i = 1; i < got.size(); i++) begin
            if (got[i].t != got[i-1].t + 1) begin
                check(1'b0, "R12", $sformatf("gap before beat %0d actual cycle %0d expected %0d",
                                             i, got[i].t, got[i-1].t + 1));
            end
        end
        qa.delete(); qn.delete(); ex.delete();
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(ov_a == 1'b0, "R1", $sformatf("out_valid actual %b expected 0", ov_a));
        check(busy_a == 1'b0, "R1", $sformatf("rel_busy actual %b expected 0", busy_a));
        cmd(1, 0, 0, 0);
        check_out(0, "R1");
    endtask

    task automatic t_order();
        do_reset();
        send_pkt(1, 1, 1); send_pkt(2, 2, 1); send_pkt(3, 4, 1);
        cmd(1, 0, 1, 0);
        exp_pkt(1, 1, 1); exp_pkt(2, 2, 1); exp_pkt(3, 4, 1);
        check_out(0, "R2");
        cmd(1, 0, 1, 0);
        exp_pkt(1, 1, 1); exp_pkt(2, 2, 1); exp_pkt(3, 4, 1);
        check_out(0, "R6");
        cmd(0, 1, 1, 0);
        cmd(1, 0, 1, 0);
        check_out(0, "R7");
    endtask

    task automatic t_bad_len();
        do_reset();
        send_pkt(4, 3, 2);
        send_pkt(5, 5, 2);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 16'hBEEF; in_frame = 4'd2;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        send_pkt(6, 1, 2);
        cmd(1, 0, 2, 0);
        exp_pkt(6, 1, 2);
        check_out(0, "R3");
    endtask

    task automatic t_evict();
        do_reset();
        send_pkt(7, 4, 2); send_pkt(8, 4, 2);
        cmd(1, 0, 2, 0);
        exp_pkt(7, 4, 2); exp_pkt(8, 4, 2);
        check_out(0, "R4");
        send_pkt(9, 1, 2);
        cmd(1, 0, 2, 0);
        exp_pkt(8, 4, 2); exp_pkt(9, 1, 2);
        check_out(0, "R5");
        send_pkt(10, 4, 2);
        cmd(1, 0, 2, 0);
        exp_pkt(9, 1, 2); exp_pkt(10, 4, 2);
        check_out(0, "R5");
    endtask

    task automatic t_tags();
        do_reset();
        send_pkt(1, 1, 3); send_pkt(2, 2, 3); send_pkt(3, 1, 4);
        cmd(1, 0, 4, 0);
        check_out(0, "R6");
        cmd(1, 0, 3, 0);
        exp_pkt(1, 1, 3); exp_pkt(2, 2, 3);
        check_out(0, "R6");
        cmd(0, 1, 3, 0);
        cmd(1, 0, 4, 0);
        exp_pkt(3, 1, 4);
        check_out(0, "R7");
        cmd(0, 1, 5, 0);
        cmd(1, 0, 4, 0);
        exp_pkt(3, 1, 4);
        check_out(0, "R7");
    endtask

    task automatic t_busy();
        do_reset();
        for (int i = 0; i < 4; i++) send_pkt(11 + i, 1, 6);
        @(negedge clk);
        rel_frame = 4'd6; rel_play = 1'b1;
        @(negedge clk);
        rel_play = 1'b0;
        check(busy_a == 1'b1, "R9", $sformatf("rel_busy actual %b expected 1", busy_a));
        rel_free = 1'b1;
        @(negedge clk);
        rel_free = 1'b0;
        wait_idle();
        for (int i = 0; i < 4; i++) exp_pkt(11 + i, 1, 6);
        check_out(0, "R9");
        cmd(1, 0, 6, 0);
        for (int i = 0; i < 4; i++) exp_pkt(11 + i, 1, 6);
        check_out(0, "R9");
        cmd(1, 1, 6, 0);
        for (int i = 0; i < 4; i++) exp_pkt(11 + i, 1, 6);
        check_out(0, "R9");
        cmd(1, 0, 6, 0);
        for (int i = 0; i < 4; i++) exp_pkt(11 + i, 1, 6);
        check_out(0, "R9");
    endtask

    task automatic t_protect();
        do_reset();
        send_pkt(1, 4, 7); send_pkt(2, 4, 7);
        @(negedge clk);
        rel_frame = 4'd7; rel_play = 1'b1;
        @(negedge clk);
        rel_play = 1'b0;
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 16'h0F00; in_frame = 4'd7;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        wait_idle();
        exp_pkt(1, 4, 7); exp_pkt(2, 4, 7);
        check_out(0, "R10");
        cmd(1, 0, 7, 0);
        exp_pkt(1, 4, 7); exp_pkt(2, 4, 7);
        check_out(0, "R10");
    endtask

    task automatic t_no_assoc();
        do_reset();
        send_pkt(1, 1, 1); send_pkt(2, 2, 2);
        cmd(1, 0, 9, 1);
        exp_pkt(1, 1, 1); exp_pkt(2, 2, 2);
        check_out(1, "R8");
        cmd(1, 0, 9, 1);
        check_out(1, "R8");
        send_pkt(3, 4, 5);
        cmd(0, 1, 5, 1);
        cmd(1, 0, 5, 1);
        exp_pkt(3, 4, 5);
        check_out(1, "R8");
    endtask

    initial begin
        t_reset();
        t_order();
        t_bad_len();
        t_evict();
        t_tags();
        t_busy();
        t_protect();
        t_no_assoc();
        check(zhits == 0, "R11", $sformatf("zero-capacity activity actual %0d expected 0", zhits));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule